// File: doc/BRIEF.md
# Peak-Current PWM Chopper for One Bridge Phase

This block keeps the winding current of one full bridge under a target level. One copy serves each phase, and the copies share nothing, so each phase is regulated on its own. A free-running counter splits time into fixed periods. The count does not depend on the load or on the command. While the bridge command asks for forward or reverse drive, the drive is on at the start of every period. An external comparator, already brought into the clock domain, raises a one-bit trip flag when the sensed current reaches the target. This block reacts to that flag with a peak-detect rule: the first trip it accepts in a period forces the bridge into low-side recirculation, with both legs low, for the rest of that period.

The comparator output is not trusted at the start of each on-time. It is masked for a short blanking window so that switching spikes cannot end the pulse early. A trip that arrives inside that window is dropped and is not remembered. The chop output tells the bridge decoder to replace its own leg pattern with recirculation. A status output tells whether regulation cut in during the period that just ended. With a 4 MHz clock, the default period of 184 cycles gives a rate close to 21.7 kHz, and the default blanking of 14 cycles lasts 3.5 µs.

Top module: `peak_chopper`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, chop_o and trip_stat_o are 0. The period counter restarts so that the first cycle after release is cycle 0 of a period.
- R2: The period counter runs without stopping and wraps after PERIOD_CYC cycles (default 184), whatever the command or the trip flag does. chop_o is 0 in cycle 0 of every period.
- R3: Cycles 0 to BLANK_CYC-1 of each period (default 0 to 13) form the blanking window. A trip flag seen in those cycles is dropped and not stored, so a trip pulse that ends inside the window leaves chop_o and trip_stat_o unchanged.
- R4: drive_cmd_i value 3 means forward drive and value 2 means reverse drive. When a drive command is present and trip_i is 1 in a cycle at or after BLANK_CYC that is not the last cycle of the period, chop_o goes to 1 in the next cycle. It then stays at 1 until the period ends, even after trip_i falls.
- R5: chop_o returns to 0 in cycle 0 of the next period, whatever trip_i and drive_cmd_i are doing.
- R6: drive_cmd_i values 0 (high impedance), 1 (low-side brake), 4 (high-side recirculation) and 5 to 7 (unused) are not drive commands. Under these values a trip is ignored, chop_o stays 0 and the counter keeps running.
- R7: If drive_cmd_i stops being a drive command while chop_o is 1, chop_o falls to 0 in the next cycle.
- R8: In cycle 0 of each period, trip_stat_o is loaded with 1 if a trip was accepted (under R3, R4 and R6) at any time in the period just ended, and with 0 if none was. It does not change during the rest of the period.
- R9: A trip accepted in the last cycle of a period does not raise chop_o, because the new period begins with the drive on. It still sets trip_stat_o for the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (4 MHz in the target system) |
| rst_n | input | 1 | Synchronous reset, active low |
| drive_cmd_i | input | 3 | Leg pattern requested by the bridge decoder (codes given in R4 and R6) |
| trip_i | input | 1 | Synchronized current comparator flag, 1 when the current has reached the target |
| chop_o | output | 1 | 1 makes the decoder hold both legs low (recirculation) |
| trip_stat_o | output | 1 | 1 when a trip was accepted in the previous period |

## Verification
Both outputs are registered. chop_o responds in the cycle after the trip or command that changes it. trip_stat_o changes only in cycle 0 of a period, based on the trips that were accepted in the period before it. The bench keeps its own cycle-accurate model of the period count and of these rules. Each time it drives an input, 4 ns after a rising edge, it adds the output values expected after the next edge to a queue. A monitor takes one item off the queue 2 ns after each edge and compares it with the outputs, so every comparison sees exactly one register stage of response.

// File: rtl/peak_chopper_pkg.sv
package peak_chopper_pkg;

    // Leg pattern requested by the bridge decoder.
    typedef enum logic [2:0] {
        CMD_HIZ       = 3'd0,
        CMD_LS_BRAKE  = 3'd1,
        CMD_REV       = 3'd2,
        CMD_FWD       = 3'd3,
        CMD_HS_RECIRC = 3'd4
    } drive_cmd_e;

    // Only the two energizing patterns are subject to chopping.
    function automatic logic is_driving(input logic [2:0] cmd);
        return (cmd == CMD_FWD) || (cmd == CMD_REV);
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int PERIOD_CYC = 184,
    parameter int BLANK_CYC  = 14
) (
    input  logic clk,
    input  logic rst_n,
    output logic blank_o,
    output logic last_o
);
    localparam int CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(PERIOD_CYC - 1);
    localparam logic [CNT_W-1:0] BLANK_END = CNT_W'(BLANK_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST_CNT) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_o = (st_q.cnt == LAST_CNT);

    generate
        if (BLANK_CYC == 0) begin : g_no_blank
            assign blank_o = 1'b0;
        end else begin : g_blank
            assign blank_o = (st_q.cnt < BLANK_END);
        end
    endgenerate

endmodule

// File: rtl/trip_gate.sv
module trip_gate
    import peak_chopper_pkg::*;
(
    input  logic [2:0] drive_cmd_i,
    input  logic       trip_i,
    input  logic       blank_i,
    output logic       driving_o,
    output logic       accept_o
);
    always_comb begin
        driving_o = is_driving(drive_cmd_i);
        // A masked or idle-state trip is dropped here and never reaches state.
        accept_o  = driving_o && trip_i && !blank_i;
    end
endmodule

// File: rtl/chop_latch.sv
module chop_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic driving_i,
    input  logic last_i,
    output logic chop_o,
    output logic stat_o
);
    typedef struct packed {
        logic chop;
        logic hit;
        logic stat;
    } cl_state_t;

    cl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (last_i) begin
            st_d.chop = 1'b0;
            st_d.hit  = 1'b0;
            st_d.stat = st_q.hit | accept_i;
        end else begin
            st_d.hit  = st_q.hit | accept_i;
            st_d.chop = driving_i & (st_q.chop | accept_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chop_o = st_q.chop;
    assign stat_o = st_q.stat;

endmodule

// File: rtl/peak_chopper.sv
module peak_chopper #(
    parameter int PERIOD_CYC = 184,
    parameter int BLANK_CYC  = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] drive_cmd_i,
    input  logic       trip_i,
    output logic       chop_o,
    output logic       trip_stat_o
);
    logic blank, last, driving, accept;

    pwm_timebase #(
        .PERIOD_CYC(PERIOD_CYC),
        .BLANK_CYC (BLANK_CYC)
    ) i_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .blank_o(blank),
        .last_o (last)
    );

    trip_gate i_gate (
        .drive_cmd_i(drive_cmd_i),
        .trip_i     (trip_i),
        .blank_i    (blank),
        .driving_o  (driving),
        .accept_o   (accept)
    );

    chop_latch i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .driving_i(driving),
        .last_i   (last),
        .chop_o   (chop_o),
        .stat_o   (trip_stat_o)
    );

endmodule

// File: rtl/peak_chopper_chk.sv
module peak_chopper_chk #(
    parameter int PERIOD_CYC = 184,
    parameter int BLANK_CYC  = 14
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] drive_cmd_i,
    input logic       trip_i,
    input logic       chop_o,
    input logic       trip_stat_o
);
    int ck_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_cnt <= 0;
        end else if (ck_cnt == PERIOD_CYC - 1) begin
            ck_cnt <= 0;
        end else begin
            ck_cnt <= ck_cnt + 1;
        end
    end

    // R3: no chop can be visible before the first unmasked trip takes effect
    a_r3_quiet_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_cnt <= BLANK_CYC) |-> !chop_o);

    // R4: a new chop always follows a trip seen one cycle earlier
    a_r4_rise_after_trip: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chop_o) |-> $past(trip_i));

    // R4: chop holds while drive stays on and the period continues
    a_r4_chop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_o && (drive_cmd_i == 3'd2 || drive_cmd_i == 3'd3) && ck_cnt != PERIOD_CYC - 1)
        |=> chop_o);

    // R5: every period opens with the drive on
    a_r5_clear_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_cnt == PERIOD_CYC - 1) |=> !chop_o);

    // R6/R7: a non-drive command leaves no chop in the next cycle
    a_r6_idle_no_chop: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_cmd_i == 3'd2 || drive_cmd_i == 3'd3) |=> !chop_o);

    // R8: status only moves at a period boundary
    a_r8_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_cnt != PERIOD_CYC - 1) |=> $stable(trip_stat_o));

endmodule

bind peak_chopper peak_chopper_chk #(
    .PERIOD_CYC(PERIOD_CYC),
    .BLANK_CYC (BLANK_CYC)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .drive_cmd_i(drive_cmd_i),
    .trip_i     (trip_i),
    .chop_o     (chop_o),
    .trip_stat_o(trip_stat_o)
);

// File: tb/test_peak_chopper.sv
module test_peak_chopper;
    localparam int PERIOD = 184;
    localparam int BLANK  = 14;
    localparam int WD_CYC = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] drive_cmd = 3'd0;
    logic       trip = 1'b0;
    logic       chop_o, trip_stat_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit    chop;
        bit    stat;
        string tag;
    } exp_t;
    exp_t q[$];
    exp_t e;

    // bench model state
    int m_cnt  = 0;
    bit m_chop = 0;
    bit m_hit  = 0;
    bit m_stat = 0;

    always #10 clk = ~clk;

    peak_chopper #(.PERIOD_CYC(PERIOD), .BLANK_CYC(BLANK)) i_peak_chopper (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_cmd_i(drive_cmd),
        .trip_i     (trip),
        .chop_o     (chop_o),
        .trip_stat_o(trip_stat_o)
    );

    task automatic check(input bit act, input bit exp_v, input string what, input string tag);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", tag, what, act, exp_v, $time);
        end
    endtask

    // Driver: apply one cycle of stimulus, predict the outputs after the next edge.
    task automatic step(input logic [2:0] cmd, input bit trip_in, input string tag);
        bit drv, acc, last;
        exp_t it;
        drive_cmd = cmd;
        trip      = trip_in;
        drv  = (cmd == 3'd2) || (cmd == 3'd3);
        acc  = drv && trip_in && (m_cnt >= BLANK);
        last = (m_cnt == PERIOD - 1);
        if (last) begin
            m_stat = m_hit | acc;
            m_hit  = 0;
            m_chop = 0;
            m_cnt  = 0;
        end else begin
            m_hit  = m_hit | acc;
            m_chop = drv && (m_chop || acc);
            m_cnt  = m_cnt + 1;
        end
        it.chop = m_chop;
        it.stat = m_stat;
        it.tag  = tag;
        q.push_back(it);
        @(posedge clk);
        #4;
    endtask

    task automatic run_period(input logic [2:0] cmd_a, input logic [2:0] cmd_b, input int sw,
                              input int lo, input int hi, input string tag);
        for (int c = 0; c < PERIOD; c++) begin
            step((c < sw) ? cmd_a : cmd_b, (c >= lo) && (c <= hi), tag);
        end
    endtask

    // Monitor
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            check(chop_o, e.chop, "chop_o", e.tag);
            check(trip_stat_o, e.stat, "trip_stat_o", e.tag);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #4;
        check(chop_o, 1'b0, "chop_o in reset", "R1");
        check(trip_stat_o, 1'b0, "trip_stat_o in reset", "R1");
        rst_n = 1'b1;

        run_period(3'd0, 3'd0, PERIOD, 1, 0, "R1 R2 idle");
        run_period(3'd1, 3'd1, PERIOD, 0, PERIOD - 1, "R6 low brake");
        run_period(3'd4, 3'd4, PERIOD, 0, PERIOD - 1, "R6 high recirc");
        run_period(3'd6, 3'd6, PERIOD, 0, PERIOD - 1, "R6 unused code");
        run_period(3'd3, 3'd3, PERIOD, 5, 5, "R3 pulse in blank");
        run_period(3'd3, 3'd3, PERIOD, BLANK - 1, BLANK - 1, "R3 last blank cycle");
        run_period(3'd3, 3'd3, PERIOD, BLANK, BLANK, "R4 first open cycle");
        run_period(3'd3, 3'd3, PERIOD, 50, 52, "R4 R5 R8 mid period");
        run_period(3'd2, 3'd2, PERIOD, 0, PERIOD - 1, "R3 R4 reverse held trip");
        run_period(3'd3, 3'd0, 80, 30, 30, "R7 drive dropped");
        run_period(3'd3, 3'd3, PERIOD, PERIOD - 1, PERIOD - 1, "R9 last cycle trip");
        run_period(3'd3, 3'd3, PERIOD, 1, 0, "R8 status clears");
        run_period(3'd0, 3'd0, PERIOD, 1, 0, "R2 R8 idle tail");

        @(posedge clk);
        #4;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule